// File: doc/BRIEF.md
# Configurable SPI Character Engine

This block shifts one serial character at a time, as either the clock-driving master or a clocked slave. All settings come from a 16-bit control word. The control word selects clock phase, idle clock level, bit order, 7-bit or 8-bit characters, the role, and the pin arrangement. The pin arrangement is either three wires, or four wires with a select line that is active high or active low. Software reset is bit 0 of the word and is set at power-up. It keeps every shifting register cleared. All other fields of the word can be changed only while this bit is set.

On the host side there is a control write port with readback, a strobe that loads the transmit byte, a received byte with a one-cycle valid pulse, a busy flag and a sticky conflict flag. As master, the block divides its clock by twice `HALF_DIV` to produce SCLK. In four-wire master mode the select line has two uses. As an input, it aborts the transfer when another master claims the bus. As an output, it drives the select of the attached slave. As slave, the block synchronises SCLK, MOSI and the select line into its own clock. When the select line is inactive, it releases MISO and keeps its place within the character.

Top module: `spi_char_engine`

## Requirements
- R1: After reset the control word reads 0x01C1. Bits 5..2 always read 0, even after a write of 0xFFFF while bit 0 is 1.
- R2: While bit 0 (software reset) is 0, a control write changes only bit 0. Bits 15..1 keep their values.
- R3: As master (bit 11 = 1), SCLK rests at the level of bit 14 whenever no transfer runs. It makes exactly 2·N transitions per character, where N is 8, or 7 when bit 12 = 1.
- R4: Bit 15 = 0 places data changes on the second SCLK edge of each bit and sampling on the first. Bit 15 = 1 samples on the second edge and changes data on the first. This holds in both roles.
- R5: Bit 13 = 1 shifts the most significant bit first and 0 the least significant first, for transmit and receive alike.
- R6: With bit 12 = 1 only bits 6..0 of the transmit byte are sent, and received bytes have bit 7 = 0 in either bit order.
- R7: rx_valid is a single-cycle pulse that carries the completed character on rx_data. Busy is high during a master transfer and during a partial slave character.
- R8: As slave, mode field bits 10..9 enable shifting and MISO drive as follows: 00 always, 01 while the select line is high, 10 while it is low, 11 never.
- R9: A slave disabled through the select line ignores SCLK edges and keeps its bit count. It completes the character correctly once enabled again.
- R10: Conflict detection applies to a master in mode 01 or 10 with bit 1 = 0. There, an active select line aborts the transfer, returns SCLK to idle and sets a sticky conflict flag. The flag blocks new transfers and is cleared only by software reset.
- R11: A master in mode 01 or 10 with bit 1 = 1 drives the select line at its active level while busy and at its inactive level otherwise.
- R12: Bit 1 has no effect in slave mode or in mode 00. A three-wire master ignores the select input.
- R13: While software reset is 1, a transmit load starts nothing and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word readback |
| tx_load | input | 1 | Load strobe for the transmit byte; starts a master transfer |
| tx_data | input | 8 | Transmit byte |
| rx_data | output | 8 | Last received character |
| rx_valid | output | 1 | One-cycle pulse when rx_data updates |
| busy | output | 1 | Transfer or partial character in progress |
| conflict | output | 1 | Sticky bus-conflict flag |
| sclk_i | input | 1 | Serial clock from an external master |
| sclk_o | output | 1 | Serial clock driven as master |
| sclk_oe | output | 1 | Drive enable for sclk_o |
| mosi_i | input | 1 | Serial data into the slave |
| mosi_o | output | 1 | Serial data out of the master |
| mosi_oe | output | 1 | Drive enable for mosi_o |
| miso_i | input | 1 | Serial data into the master |
| miso_o | output | 1 | Serial data out of the slave |
| miso_oe | output | 1 | Drive enable for miso_o (low when tri-stated) |
| ste_i | input | 1 | Select line input |
| ste_o | output | 1 | Select line output in master drive mode |
| ste_oe | output | 1 | Drive enable for ste_o |

## Verification
A control write shows on the readback one clock later, and the bench reads it on the following falling edge. In master mode, rx_valid comes one clock after the SCLK edge that samples the last bit. For slave transfers the bench allows for the two-stage synchroniser plus one register, about three clocks, and waits at least eight clocks between serial edges. A select-line conflict clears busy within three clocks, and the bench checks it six clocks after the line changes. The bench pushes every received character into a queue when it starts the transfer, and a monitor pops and compares the queue on each rx_valid. This keeps the comparison tied to the pulse and not to a counted delay.

// File: rtl/spi_eng_pkg.sv
// Package: shared types and constants for the SPI character engine.
// Assumes characters are at most CHAR_W bits and the short length is CHAR_W-1.
package spi_eng_pkg;
    localparam int CHAR_W = 8;
    localparam int CNT_W  = $clog2(CHAR_W + 1);
    localparam int IDX_W  = $clog2(CHAR_W);

    // Control word, bit 15 first.
    typedef struct packed {
        logic       cpha;
        logic       cpol;
        logic       msb_first;
        logic       len_short;
        logic       master;
        logic [1:0] pin_mode;
        logic       sync_mode;
        logic [1:0] clk_sel;
        logic [3:0] rsvd;
        logic       ste_drive;
        logic       srst;
    } ctl_word_t;

    localparam logic [15:0] CTL_RESET = 16'h01C1;
    localparam logic [15:0] CTL_RSVD  = 16'h003C;
    localparam logic [1:0]  PINS_3    = 2'b00;
    localparam logic [1:0]  PINS_4_HI = 2'b01;
    localparam logic [1:0]  PINS_4_LO = 2'b10;
    localparam logic [1:0]  PINS_OFF  = 2'b11;

    // Register index of the bit sent or received at position pos.
    function automatic logic [IDX_W-1:0] bit_slot(input logic msb,
                                                  input logic [CNT_W-1:0] nbits,
                                                  input logic [CNT_W-1:0] pos);
        logic [CNT_W-1:0] t;
        t = msb ? (nbits - CNT_W'(1) - pos) : pos;
        return t[IDX_W-1:0];
    endfunction
endpackage

// File: rtl/spi_ctl_reg.sv
// Control word register with a write lock.
// Assumes: with bit 0 set, the whole word is writable (reserved bits forced to 0);
// with bit 0 clear, only bit 0 is writable.
module spi_ctl_reg
    import spi_eng_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output ctl_word_t   ctl
);
    logic [15:0] word_q;

    // Store the control word; only bit 0 is accepted while unlocked for operation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= CTL_RESET;
        else if (wr_en) begin
            if (word_q[0])
                word_q <= wr_data & ~CTL_RSVD;
            else
                word_q[0] <= wr_data[0];
        end
    end

    assign ctl = ctl_word_t'(word_q);

    a_r2_lock_fields: assert property (@(posedge clk) disable iff (!rst_n)
        !word_q[0] |=> word_q[15:1] == $past(word_q[15:1]));
    a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        word_q[5:2] == 4'b0000);
endmodule

// File: rtl/spi_edge_gen.sv
// Edge source: as master it divides clk into SCLK and marks the leading and trailing
// edges of each bit; as slave it marks the edges of a synchronised external SCLK.
// Assumes HALF_DIV >= 1 and that sclk_in has already passed a synchroniser.
module spi_edge_gen
    import spi_eng_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             master,
    input  logic             cpol,
    input  logic             start,
    input  logic             abort,
    input  logic [CNT_W-1:0] nbits,
    input  logic             sclk_in,
    input  logic             slave_en,
    output logic             lead,
    output logic             trail,
    output logic             sclk_out,
    output logic             m_active
);
    localparam int DIV_W  = $clog2(HALF_DIV + 1);
    localparam int EDGE_W = CNT_W + 1;

    logic [DIV_W-1:0]  div_q;
    logic [EDGE_W-1:0] edge_q;
    logic              lvl_q;
    logic              prev_q;
    logic              m_edge;
    logic              s_edge;
    logic [EDGE_W-1:0] last_edge;

    assign last_edge = {nbits, 1'b0} - EDGE_W'(1);
    assign m_edge    = m_active && (div_q == DIV_W'(HALF_DIV - 1));

    // Master divider: counts half periods and edges of the current character.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || abort) begin
            m_active <= 1'b0;
            div_q    <= '0;
            edge_q   <= '0;
            lvl_q    <= 1'b0;
        end else if (start && !m_active) begin
            m_active <= 1'b1;
            div_q    <= '0;
            edge_q   <= '0;
            lvl_q    <= 1'b0;
        end else if (m_active) begin
            if (m_edge) begin
                div_q  <= '0;
                lvl_q  <= ~lvl_q;
                edge_q <= edge_q + EDGE_W'(1);
                if (edge_q == last_edge)
                    m_active <= 1'b0;
            end else begin
                div_q <= div_q + DIV_W'(1);
            end
        end
    end

    // Slave edge detector: remembers the previous synchronised SCLK level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else
            prev_q <= sclk_in;
    end

    assign s_edge   = slave_en && (prev_q != sclk_in);
    assign sclk_out = cpol ^ lvl_q;
    assign lead     = master ? (m_edge && !edge_q[0]) : (s_edge && (sclk_in != cpol));
    assign trail    = master ? (m_edge &&  edge_q[0]) : (s_edge && (sclk_in == cpol));

    a_r3_lead_trail_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead && trail));
endmodule

// File: rtl/spi_shift_core.sv
// Shift core: keeps the transmit byte and drives one data bit per change edge. It
// assembles received bits at sample edges, and reports each whole character once.
// Assumes lead and trail are single-cycle pulses and never coincide.
module spi_shift_core
    import spi_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cpha,
    input  logic              msb_first,
    input  logic              len_short,
    input  logic              load,
    input  logic [CHAR_W-1:0] tx_byte,
    input  logic              lead,
    input  logic              trail,
    input  logic              rx_bit,
    output logic              out_bit,
    output logic [CHAR_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              mid_char
);
    logic [CNT_W-1:0]  nbits;
    logic [CNT_W-1:0]  tx_pos;
    logic [CNT_W-1:0]  rx_pos;
    logic [CHAR_W-1:0] tx_q;
    logic [CHAR_W-1:0] acc_q;
    logic [CHAR_W-1:0] acc_nxt;
    logic              chg;
    logic              smp;

    assign nbits = len_short ? CNT_W'(CHAR_W - 1) : CNT_W'(CHAR_W);
    assign chg   = cpha ? lead  : trail;
    assign smp   = cpha ? trail : lead;

    // Next receive accumulator: insert the sampled bit at its ordered slot.
    always_comb begin
        acc_nxt = acc_q;
        acc_nxt[bit_slot(msb_first, nbits, rx_pos)] = rx_bit;
    end

    // Transmit and receive sequencing for one character.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            tx_q     <= '0;
            tx_pos   <= '0;
            rx_pos   <= '0;
            acc_q    <= '0;
            out_bit  <= 1'b0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (load) begin
                tx_q    <= tx_byte;
                tx_pos  <= cpha ? CNT_W'(0) : CNT_W'(1);
                out_bit <= tx_byte[bit_slot(msb_first, nbits, '0)];
                rx_pos  <= '0;
                acc_q   <= '0;
            end else begin
                if (chg) begin
                    if (tx_pos == nbits) begin
                        out_bit <= tx_q[bit_slot(msb_first, nbits, '0)];
                        tx_pos  <= CNT_W'(1);
                    end else begin
                        out_bit <= tx_q[bit_slot(msb_first, nbits, tx_pos)];
                        tx_pos  <= tx_pos + CNT_W'(1);
                    end
                end
                if (smp) begin
                    if (rx_pos == nbits - CNT_W'(1)) begin
                        rx_byte  <= len_short ? {1'b0, acc_nxt[CHAR_W-2:0]} : acc_nxt;
                        rx_valid <= 1'b1;
                        rx_pos   <= '0;
                        acc_q    <= '0;
                    end else begin
                        rx_pos <= rx_pos + CNT_W'(1);
                        acc_q  <= acc_nxt;
                    end
                end
            end
        end
    end

    assign mid_char = (rx_pos != '0);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !lead && !trail && !load) |=> $stable(rx_pos));
endmodule

// File: rtl/spi_char_engine.sv
// Top of the SPI character engine. It synchronises the slave-side pins and decodes
// role and pin mode into enables. It detects bus conflicts and drives the serial pins.
// Assumes external pins are asynchronous to clk; master-side miso_i is sampled directly.
module spi_char_engine
    import spi_eng_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    input  logic              tx_load,
    input  logic [CHAR_W-1:0] tx_data,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              busy,
    output logic              conflict,
    input  logic              sclk_i,
    output logic              sclk_o,
    output logic              sclk_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ste_i,
    output logic              ste_o,
    output logic              ste_oe
);
    ctl_word_t        ctl;
    logic [1:0]       sclk_sy, mosi_sy, ste_sy;
    logic             run, pins_ok, four_pin, ste_active;
    logic             slave_en, conflict_det, conflict_q;
    logic             m_active, m_start, load, lead, trail, out_bit, mid_char;
    logic             edge_sclk;
    logic [CNT_W-1:0] nbits;

    spi_ctl_reg u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .ctl     (ctl)
    );

    // Two-stage synchronisers for the pins an external master drives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_sy <= '0;
            mosi_sy <= '0;
            ste_sy  <= '0;
        end else begin
            sclk_sy <= {sclk_sy[0], sclk_i};
            mosi_sy <= {mosi_sy[0], mosi_i};
            ste_sy  <= {ste_sy[0],  ste_i};
        end
    end

    assign run          = !ctl.srst;
    assign pins_ok      = (ctl.pin_mode != PINS_OFF);
    assign four_pin     = (ctl.pin_mode == PINS_4_HI) || (ctl.pin_mode == PINS_4_LO);
    assign ste_active   = (ctl.pin_mode == PINS_4_HI) ? ste_sy[1] : !ste_sy[1];
    assign slave_en     = run && !ctl.master && pins_ok && (!four_pin || ste_active);
    assign conflict_det = run && ctl.master && four_pin && !ctl.ste_drive && ste_active;
    assign m_start      = tx_load && run && ctl.master && pins_ok
                          && !conflict_q && !conflict_det && !m_active;
    assign load         = ctl.master ? m_start : (tx_load && run && !mid_char);
    assign nbits        = ctl.len_short ? CNT_W'(CHAR_W - 1) : CNT_W'(CHAR_W);

    // Sticky conflict flag, cleared only while software reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n || ctl.srst)
            conflict_q <= 1'b0;
        else if (conflict_det)
            conflict_q <= 1'b1;
    end

    spi_edge_gen #(.HALF_DIV(HALF_DIV)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .master   (ctl.master),
        .cpol     (ctl.cpol),
        .start    (m_start),
        .abort    (conflict_det),
        .nbits    (nbits),
        .sclk_in  (sclk_sy[1]),
        .slave_en (slave_en),
        .lead     (lead),
        .trail    (trail),
        .sclk_out (edge_sclk),
        .m_active (m_active)
    );

    spi_shift_core u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .cpha      (ctl.cpha),
        .msb_first (ctl.msb_first),
        .len_short (ctl.len_short),
        .load      (load),
        .tx_byte   (tx_data),
        .lead      (lead),
        .trail     (trail),
        .rx_bit    (ctl.master ? miso_i : mosi_sy[1]),
        .out_bit   (out_bit),
        .rx_byte   (rx_data),
        .rx_valid  (rx_valid),
        .mid_char  (mid_char)
    );

    assign cfg_rdata = ctl;
    assign busy      = ctl.master ? m_active : mid_char;
    assign conflict  = conflict_q;
    assign sclk_o    = edge_sclk;
    assign sclk_oe   = ctl.master && pins_ok;
    assign mosi_o    = out_bit;
    assign mosi_oe   = ctl.master && pins_ok;
    assign miso_o    = out_bit;
    assign miso_oe   = slave_en;
    assign ste_o     = (ctl.pin_mode == PINS_4_HI) ? m_active : !m_active;
    assign ste_oe    = ctl.master && four_pin && ctl.ste_drive;

    a_r3_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.master && !busy) |-> (sclk_o == ctl.cpol));
    a_r10_conflict_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict && !ctl.srst) |=> conflict);
    a_r13_srst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.srst |=> !busy);
    a_r8_miso_slave_only: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> !ctl.master);
endmodule

// File: tb/spi_char_engine_tb_top.sv
`timescale 1ns/1ps
module spi_char_engine_tb_top;
    localparam int HALF = 4;
    localparam int SH   = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic       tx_load = 1'b0;
    logic [7:0] tx_data = '0;
    logic [7:0] rx_data;
    logic       rx_valid, busy, conflict;
    logic       sclk_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ste_i = 1'b0;
    logic       sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe, ste_o, ste_oe;

    int n_run = 0, n_fail = 0, sb_run = 0, sb_fail = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    spi_char_engine #(.HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tx_load(tx_load), .tx_data(tx_data),
        .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy), .conflict(conflict),
        .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ste_i(ste_i), .ste_o(ste_o), .ste_oe(ste_oe)
    );

    // Monitor: pop the expected character on every rx_valid pulse (R7).
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            sb_run++;
            if (exp_q.size() == 0) begin
                sb_fail++;
                $display("FAIL R7 unexpected rx_valid actual=%02h expected=none", rx_data);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (rx_data !== e) begin
                    sb_fail++;
                    $display("FAIL R5/R6/R7 rx_data actual=%02h expected=%02h", rx_data, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run + sb_run + 1, n_fail + sb_fail + 1);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ctlw(input bit cpha, cpol, msb, l7, mst,
                                         input logic [1:0] mode, input bit sdrv, srst);
        return {cpha, cpol, msb, l7, mst, mode, 1'b1, 2'b11, 4'b0000, sdrv, srst};
    endfunction

    function automatic logic [7:0] msk(input logic [7:0] d, input bit l7);
        return l7 ? {1'b0, d[6:0]} : d;
    endfunction

    function automatic int slot(input int k, input bit msb, input bit l7);
        int n;
        n = l7 ? 7 : 8;
        return msb ? n - 1 - k : k;
    endfunction

    task automatic wr(input logic [15:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic setup(input logic [15:0] word);
        wr(16'h0001);
        wr(word);
        repeat (4) @(negedge clk);
    endtask

    // Master transfer with the bench acting as slave on the serial pins.
    task automatic m_xfer(input logic [7:0] mtx, stx, input bit cpha, cpol, msb, l7,
                          input logic [1:0] mode, input bit sdrv);
        int n, edges, bo, bi;
        logic [7:0] cap;
        n = l7 ? 7 : 8; edges = 0; bi = 0; cap = '0;
        setup(ctlw(cpha, cpol, msb, l7, 1'b1, mode, sdrv, 1'b0));
        chk(sclk_o == cpol, "R3 idle sclk", sclk_o, cpol);
        if (sdrv && mode != 2'b00)
            chk(ste_oe && ste_o == (mode != 2'b01), "R11 ste idle", ste_o, mode != 2'b01);
        if (cpha) bo = 0; else begin miso_i = stx[slot(0, msb, l7)]; bo = 1; end
        exp_q.push_back(msk(stx, l7));
        fork
            begin
                @(negedge clk); tx_load = 1'b1; tx_data = mtx;
                @(negedge clk); tx_load = 1'b0;
            end
            begin
                for (int e = 0; e < 2 * n; e++) begin
                    @(sclk_o);
                    edges++;
                    if (e == 0 && sdrv && mode != 2'b00)
                        chk(ste_o == (mode == 2'b01), "R11 ste active", ste_o, mode == 2'b01);
                    if (sclk_o != cpol) begin
                        if (cpha) begin miso_i = stx[slot(bo, msb, l7)]; bo++; end
                        else begin cap[slot(bi, msb, l7)] = mosi_o; bi++; end
                    end else begin
                        if (cpha) begin cap[slot(bi, msb, l7)] = mosi_o; bi++; end
                        else begin if (bo < n) miso_i = stx[slot(bo, msb, l7)]; bo++; end
                    end
                end
            end
        join
        repeat (3 * HALF + 4) @(negedge clk);
        chk(edges == 2 * n, "R3 edge count", edges, 2 * n);
        chk(sclk_o == cpol && !busy, "R3 idle after", sclk_o, cpol);
        chk(cap == msk(mtx, l7), "R4/R5/R6 mosi char", cap, msk(mtx, l7));
    endtask

    // Bench-as-master state for slave transfers.
    bit sc_cpha, sc_cpol, sc_msb, sc_l7;
    logic [7:0] sc_mtx, sc_cap;

    task automatic s_bits(input int from, input int upto);
        for (int k = from; k < upto; k++) begin
            if (!sc_cpha) begin
                mosi_i = sc_mtx[slot(k, sc_msb, sc_l7)];
                repeat (SH) @(negedge clk);
                sc_cap[slot(k, sc_msb, sc_l7)] = miso_o;
                sclk_i = ~sc_cpol;
                repeat (SH) @(negedge clk);
                sclk_i = sc_cpol;
            end else begin
                repeat (SH) @(negedge clk);
                sclk_i = ~sc_cpol;
                mosi_i = sc_mtx[slot(k, sc_msb, sc_l7)];
                repeat (SH) @(negedge clk);
                sc_cap[slot(k, sc_msb, sc_l7)] = miso_o;
                sclk_i = sc_cpol;
            end
        end
    endtask

    task automatic s_prep(input logic [7:0] mtx, stx, input bit cpha, cpol, msb, l7,
                          input logic [1:0] mode, input bit sdrv, input bit ste_lvl);
        sc_cpha = cpha; sc_cpol = cpol; sc_msb = msb; sc_l7 = l7; sc_mtx = mtx; sc_cap = '0;
        sclk_i = cpol; ste_i = ste_lvl;
        repeat (4) @(negedge clk);
        setup(ctlw(cpha, cpol, msb, l7, 1'b0, mode, sdrv, 1'b0));
        @(negedge clk); tx_load = 1'b1; tx_data = stx;
        @(negedge clk); tx_load = 1'b0;
        exp_q.push_back(msk(mtx, l7));
    endtask

    task automatic s_xfer(input logic [7:0] mtx, stx, input bit cpha, cpol, msb, l7,
                          input logic [1:0] mode, input bit sdrv, input bit ste_lvl);
        s_prep(mtx, stx, cpha, cpol, msb, l7, mode, sdrv, ste_lvl);
        chk(miso_oe, "R8 slave enabled", miso_oe, 1);
        s_bits(0, l7 ? 7 : 8);
        repeat (10) @(negedge clk);
        chk(sc_cap == msk(stx, l7), "R4/R5 slave miso char", sc_cap, msk(stx, l7));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset value and reserved bits
        chk(cfg_rdata == 16'h01C1, "R1 reset word", cfg_rdata, 16'h01C1);
        chk(!busy && !conflict && !rx_valid, "R1 reset outputs", busy, 0);
        wr(16'hFFFF); @(negedge clk);
        chk(cfg_rdata == 16'hFFC3, "R1 reserved zero", cfg_rdata, 16'hFFC3);
        // R2 lock while running
        wr(16'h0800); wr(16'hF7FE); @(negedge clk);
        chk(cfg_rdata == 16'h0800, "R2 write lock", cfg_rdata, 16'h0800);
        // R13 load while held in reset starts nothing
        wr(16'h0001); wr(16'h0801); ste_i = 1'b0;
        @(negedge clk); tx_load = 1'b1; tx_data = 8'hA5;
        @(negedge clk); tx_load = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && sclk_o == 1'b0, "R13 srst holds", busy, 0);
        // Master transfers: R3 R4 R5 R6 R7
        m_xfer(8'hA5, 8'h3C, 0, 0, 1, 0, 2'b00, 0);
        m_xfer(8'h96, 8'h5A, 1, 0, 1, 0, 2'b00, 0);
        m_xfer(8'h81, 8'h7E, 0, 1, 0, 0, 2'b00, 0);
        m_xfer(8'h13, 8'hC8, 1, 1, 0, 0, 2'b00, 0);
        m_xfer(8'hFF, 8'hD5, 0, 0, 1, 1, 2'b00, 0);   // R6 msb first
        m_xfer(8'h80, 8'hAA, 1, 1, 0, 1, 2'b00, 0);   // R6 lsb first
        // R11 select driven by master
        m_xfer(8'h6B, 8'h19, 0, 0, 1, 0, 2'b10, 1);
        m_xfer(8'h2D, 8'hE4, 1, 0, 0, 0, 2'b01, 1);
        // R12 three-wire master ignores the select input
        ste_i = 1'b1;
        m_xfer(8'h47, 8'hB2, 0, 1, 1, 0, 2'b00, 1);
        chk(!conflict && !ste_oe, "R12 3-pin master", conflict, 0);
        // R10 conflict abort
        ste_i = 1'b0;
        setup(ctlw(0, 1, 1, 0, 1, 2'b01, 0, 0));
        @(negedge clk); tx_load = 1'b1; tx_data = 8'h55;
        @(negedge clk); tx_load = 1'b0;
        repeat (3 * HALF) @(negedge clk);
        chk(busy, "R10 running before", busy, 1);
        ste_i = 1'b1;
        repeat (6) @(negedge clk);
        chk(conflict && !busy && sclk_o == 1'b1, "R10 abort", {conflict, busy, sclk_o}, 3'b101);
        ste_i = 1'b0;
        repeat (4) @(negedge clk);
        @(negedge clk); tx_load = 1'b1;
        @(negedge clk); tx_load = 1'b0;
        repeat (4) @(negedge clk);
        chk(conflict && !busy, "R10 sticky blocks", {conflict, busy}, 2'b10);
        wr(16'h0001); @(negedge clk);
        chk(!conflict, "R10 cleared by srst", conflict, 0);
        // Slave transfers: R4 R5 R6 R8 R12
        s_xfer(8'h5C, 8'hA3, 0, 0, 1, 0, 2'b00, 0, 1'b0);
        s_xfer(8'h0F, 8'hF0, 1, 1, 0, 0, 2'b01, 0, 1'b1);
        s_xfer(8'hFF, 8'h81, 0, 1, 1, 1, 2'b10, 0, 1'b0);
        s_xfer(8'h3A, 8'hC5, 1, 0, 1, 0, 2'b00, 1, 1'b1);   // R12 drive bit in slave
        // R8 disabled slave: wrong select level, and mode 11
        sclk_i = 1'b0; ste_i = 1'b1;
        setup(ctlw(0, 0, 1, 0, 0, 2'b10, 0, 0));
        chk(!miso_oe, "R8 select inactive", miso_oe, 0);
        setup(ctlw(0, 0, 1, 0, 0, 2'b11, 0, 0));
        chk(!miso_oe, "R8 mode 11", miso_oe, 0);
        // R9 pause and resume
        s_prep(8'hC6, 8'h9D, 0, 0, 1, 0, 2'b01, 0, 1'b1);
        s_bits(0, 4);
        ste_i = 1'b0;
        repeat (6) @(negedge clk);
        chk(!miso_oe && busy, "R9 paused", {miso_oe, busy}, 2'b01);
        for (int j = 0; j < 3; j++) begin
            mosi_i = ~mosi_i;
            repeat (SH) @(negedge clk); sclk_i = 1'b1;
            repeat (SH) @(negedge clk); sclk_i = 1'b0;
        end
        chk(busy, "R9 count kept", busy, 1);
        ste_i = 1'b1;
        repeat (6) @(negedge clk);
        s_bits(4, 8);
        repeat (10) @(negedge clk);
        chk(sc_cap == 8'h9D, "R9 resumed char", sc_cap, 8'h9D);
        chk(exp_q.size() == 0, "R7 all chars seen", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_run + sb_run, n_fail + sb_fail);
        $finish;
    end
endmodule